// File: doc/BRIEF.md
# Transceiver Channel Selection Controller

This block holds the operating channel of a 40-channel transceiver and turns it into the divide word for the frequency synthesizer. Up and down requests come from mechanical keys. Each key passes through a sampled filter, and each accepted press moves the channel by one step. An emergency input forces the fixed emergency channel while it is high. A hold input freezes the selection. A chip-enable input switches the whole block between running and standby.

The divide word depends on the channel and on the transmit/receive select. The transmit values follow the channel raster, which has gaps and a swapped group of three channels, so they are computed from a slot index rather than from a counter. The receive values sit a fixed distance below the transmit values.

Every change of channel number raises a one-cycle pulse. The lock output is then held low for a settling window. After the window it follows the lock report from the phase detector.

Top module: `chan_sel_ctrl`

## Requirements
- R1: After reset, chan_o is 1, div_o is 3254 (receive value for channel 1), chg_o is 0, standby_o is 0 and lock_o equals lock_i.
- R2: Each accepted rising edge of a filtered up or down key moves chan_o by exactly one step in the range 1 to 40. Up from 40 gives 1, and down from 1 gives 40.
- R3: A key level is accepted only after 3 consecutive matching samples. Samples are taken once every TICK_DIV clock cycles. A key held for only 2 samples changes nothing.
- R4: With tx_i high, div_o = 5393 + 2*slot. The slot is channel-1 plus one for each boundary 4, 8, 12, 16 and 20 that the channel reaches. Channels 23, 24 and 25 take slots 29, 27 and 28.
- R5: With tx_i low, div_o is the transmit value minus 2139. div_o follows tx_i or the channel one cycle after the change.
- R6: While emg_i is high, chan_o is 9, and up or down presses have no effect. When emg_i falls, the channel held before the emergency returns.
- R7: While pa_i is high, emg_i, up_i and dn_i have no effect, and chan_o holds.
- R8: While ce_i is low, standby_o is high, chan_o and div_o hold, and chg_o stays low. Presses and tx_i changes made during standby are lost.
- R9: Fixed priority, highest first: ce_i, pa_i, emg_i, up, down. If up and down are accepted in the same cycle, up wins.
- R10: chg_o is a one-cycle pulse in the cycle where chan_o first shows a new value. No pulse occurs without a change.
- R11: lock_o is low in the chg_o cycle and for SETTLE_CYC further cycles. After that it equals lock_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Run when high, standby when low |
| pa_i | input | 1 | Hold override, freezes the selection |
| emg_i | input | 1 | Emergency channel request |
| tx_i | input | 1 | 1 selects the transmit divide value, 0 the receive value |
| up_i | input | 1 | Raw up key |
| dn_i | input | 1 | Raw down key |
| lock_i | input | 1 | Lock report from the phase detector |
| chan_o | output | 6 | Current channel, 1 to 40 |
| div_o | output | 13 | Synthesizer divide word |
| chg_o | output | 1 | Channel-change pulse |
| lock_o | output | 1 | Masked lock indication |
| standby_o | output | 1 | High in standby |

## Verification
Two events can fall in the same cycle: acceptance of an up press and acceptance of a down press. The bench provokes this by driving both keys with identical waveforms, so both filters accept on the same sampling tick. It then requires a single upward step and a single chg_o pulse. A second collision, a key press during emergency or hold, is judged from the restored channel and the unchanged pulse count.

// File: rtl/chan_pkg.sv
package chan_pkg;
  localparam int unsigned NUM_CH    = 40;
  localparam int unsigned CH_W      = $clog2(NUM_CH + 1);
  localparam int unsigned DIV_W     = 13;
  localparam int unsigned EMG_CH    = 9;
  localparam int unsigned TX_BASE   = 5393;
  localparam int unsigned RX_OFFSET = 2139;
  localparam int unsigned NUM_GAPS  = 5;
  localparam int unsigned GAP_STEP  = 4;

  typedef logic [CH_W-1:0]  chan_t;
  typedef logic [DIV_W-1:0] div_t;
endpackage

// File: rtl/chan_debounce.sv
module chan_debounce #(
  parameter int unsigned DB_SAMPLES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic raw_i,
  output logic rise_o
);
  localparam int unsigned CW = $clog2(DB_SAMPLES + 1);
  localparam logic [CW-1:0] LAST = CW'(DB_SAMPLES - 1);

  logic [CW-1:0] cnt_q;
  logic          level_q;
  logic          rise_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      level_q <= 1'b0;
      rise_q  <= 1'b0;
    end else begin
      rise_q <= tick_i && raw_i && !level_q && (cnt_q == LAST);
      if (tick_i) begin
        if (raw_i == level_q) begin
          cnt_q <= '0;
        end else if (cnt_q == LAST) begin
          level_q <= raw_i;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign rise_o = rise_q;

  // R3
  accept_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(level_q) |-> ($past(raw_i) && $past(tick_i)));
endmodule

// File: rtl/chan_core.sv
module chan_core
  import chan_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  ce_i,
  input  logic  pa_i,
  input  logic  emg_i,
  input  logic  up_i,
  input  logic  dn_i,
  output chan_t chan_o,
  output chan_t chan_nx_o,
  output logic  chg_o
);
  localparam chan_t CH_MAX = chan_t'(NUM_CH);
  localparam chan_t CH_MIN = chan_t'(1);
  localparam chan_t CH_EMG = chan_t'(EMG_CH);

  chan_t chan_q, chan_d, sav_q, sav_d;
  logic  emg_q, emg_d, chg_q;

  always_comb begin
    chan_d = chan_q;
    sav_d  = sav_q;
    emg_d  = emg_q;
    if (ce_i && !pa_i) begin
      if (emg_i && !emg_q) begin
        emg_d  = 1'b1;
        sav_d  = chan_q;
        chan_d = CH_EMG;
      end else if (!emg_i && emg_q) begin
        emg_d  = 1'b0;
        chan_d = sav_q;
      end else if (!emg_q) begin
        if (up_i)      chan_d = (chan_q == CH_MAX) ? CH_MIN : chan_q + 1'b1;
        else if (dn_i) chan_d = (chan_q == CH_MIN) ? CH_MAX : chan_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_q <= CH_MIN;
      sav_q  <= CH_MIN;
      emg_q  <= 1'b0;
      chg_q  <= 1'b0;
    end else begin
      chan_q <= chan_d;
      sav_q  <= sav_d;
      emg_q  <= emg_d;
      chg_q  <= (chan_d != chan_q);
    end
  end

  assign chan_o    = chan_q;
  assign chan_nx_o = chan_d;
  assign chg_o     = chg_q;

  // R2
  chan_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_q >= CH_MIN) && (chan_q <= CH_MAX));

  // R6
  emg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && !pa_i && emg_i && emg_q) |=> (chan_q == CH_EMG));

  // R7
  pa_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && pa_i) |=> $stable(chan_q));

  // R10
  chg_real_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_q |-> (chan_q != $past(chan_q)));
endmodule

// File: rtl/chan_divtab.sv
module chan_divtab
  import chan_pkg::*;
(
  input  chan_t chan_i,
  input  logic  tx_i,
  output div_t  div_o
);
  int gaps, slot, tx_n;

  always_comb begin
    gaps = 0;
    for (int g = 0; g < int'(NUM_GAPS); g++) begin
      if (int'(chan_i) >= int'(GAP_STEP) * (g + 1)) gaps = gaps + 1;
    end
    slot = int'(chan_i) - 1 + gaps;
    // swapped group in the raster
    case (chan_i)
      chan_t'(23): slot = 29;
      chan_t'(24): slot = 27;
      chan_t'(25): slot = 28;
      default: ;
    endcase
    tx_n  = int'(TX_BASE) + 2 * slot;
    div_o = tx_i ? div_t'(tx_n) : div_t'(tx_n - int'(RX_OFFSET));
  end
endmodule

// File: rtl/chan_settle.sv
module chan_settle #(
  parameter int unsigned SETTLE_CYC = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic chg_i,
  input  logic lock_i,
  output logic lock_o
);
  localparam int unsigned SW = $clog2(SETTLE_CYC + 1);

  logic [SW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (chg_i)         cnt_q <= SW'(SETTLE_CYC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign lock_o = lock_i && !chg_i && (cnt_q == '0);

  // R11
  mask_now_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_i |-> !lock_o);

  // R11
  mask_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_i |=> !lock_o);
endmodule

// File: rtl/chan_sel_ctrl.sv
module chan_sel_ctrl
  import chan_pkg::*;
#(
  parameter int unsigned TICK_DIV   = 4,
  parameter int unsigned DB_SAMPLES = 3,
  parameter int unsigned SETTLE_CYC = 1024
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_i,
  input  logic             pa_i,
  input  logic             emg_i,
  input  logic             tx_i,
  input  logic             up_i,
  input  logic             dn_i,
  input  logic             lock_i,
  output logic [CH_W-1:0]  chan_o,
  output logic [DIV_W-1:0] div_o,
  output logic             chg_o,
  output logic             lock_o,
  output logic             standby_o
);
  localparam int unsigned TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam div_t DIV_RST = div_t'(TX_BASE - RX_OFFSET);

  logic [TW-1:0] tick_cnt;
  logic          tick;
  logic [1:0]    raw, rise;
  chan_t         chan, chan_nx;
  div_t          div_nx, div_q;
  logic          chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   tick_cnt <= '0;
    else if (tick) tick_cnt <= '0;
    else           tick_cnt <= tick_cnt + 1'b1;
  end
  assign tick = (tick_cnt == TW'(TICK_DIV - 1));

  assign raw = {dn_i, up_i};

  for (genvar i = 0; i < 2; i++) begin : g_db
    chan_debounce #(.DB_SAMPLES(DB_SAMPLES)) u_db (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick),
      .raw_i  (raw[i]),
      .rise_o (rise[i])
    );
  end

  chan_core u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ce_i      (ce_i),
    .pa_i      (pa_i),
    .emg_i     (emg_i),
    .up_i      (rise[0]),
    .dn_i      (rise[1]),
    .chan_o    (chan),
    .chan_nx_o (chan_nx),
    .chg_o     (chg)
  );

  chan_divtab u_tab (
    .chan_i (chan_nx),
    .tx_i   (tx_i),
    .div_o  (div_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   div_q <= DIV_RST;
    else if (ce_i) div_q <= div_nx;
  end

  chan_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .chg_i  (chg),
    .lock_i (lock_i),
    .lock_o (lock_o)
  );

  assign chan_o    = chan;
  assign div_o     = div_q;
  assign chg_o     = chg;
  assign standby_o = !ce_i;

  // R8
  standby_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> ($stable(div_q) && $stable(chan) && !chg));
endmodule

// File: tb/chan_sel_ctrl_bench.sv
`timescale 1ns/1ps
module chan_sel_ctrl_bench;
  localparam int TICK_DIV = 4;
  localparam int DB       = 3;
  localparam int SETTLE   = 8;
  localparam int HOLD     = TICK_DIV * (DB + 2);

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce = 1'b1, pa = 1'b0, emg = 1'b0, tx = 1'b0, up = 1'b0, dn = 1'b0, lock = 1'b1;
  logic [5:0]  chan_o;
  logic [12:0] div_o;
  logic        chg_o, lock_o, standby_o;

  int checks = 0, fails = 0, chg_cnt = 0;
  bit done = 1'b0;

  chan_sel_ctrl #(.TICK_DIV(TICK_DIV), .DB_SAMPLES(DB), .SETTLE_CYC(SETTLE)) u_chan_sel_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .pa_i(pa), .emg_i(emg), .tx_i(tx),
    .up_i(up), .dn_i(dn), .lock_i(lock), .chan_o(chan_o), .div_o(div_o),
    .chg_o(chg_o), .lock_o(lock_o), .standby_o(standby_o)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    #1;
    if (rst_n && chg_o) chg_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(input bit u, input bit d);
    up = u; dn = d;
    cyc(HOLD);
    up = 0; dn = 0;
    cyc(HOLD);
  endtask

  // walk the raster slots, skipping the gaps; group 23..25 is reordered
  function automatic int tx_div(input int ch);
    int target, k, res;
    target = ch;
    if (ch == 23) target = 25;
    else if (ch == 24 || ch == 25) target = ch - 1;
    k = 0; res = -1;
    for (int s = 0; s <= 44; s++) begin
      if (s == 3 || s == 8 || s == 13 || s == 18 || s == 23) continue;
      k++;
      if (k == target && res < 0) res = 5393 + 2 * s;
    end
    return res;
  endfunction

  initial begin
    int c0, n;
    logic [12:0] d0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk(chan_o == 1,       "R1 chan", chan_o, 1);
    chk(div_o == 3254,     "R1 div", div_o, 3254);
    chk(chg_o == 0,        "R1 chg", chg_o, 0);
    chk(standby_o == 0,    "R1 standby", standby_o, 0);
    chk(lock_o == lock,    "R1 lock", lock_o, lock);

    for (int ch = 1; ch <= 40; ch++) begin
      tx = 1'b0; cyc(2);
      chk(div_o == tx_div(ch) - 2139, "R5 rx div", div_o, tx_div(ch) - 2139);
      tx = 1'b1; cyc(2);
      chk(div_o == tx_div(ch), "R4 tx div", div_o, tx_div(ch));
      chk(chan_o == ch, "R2 chan", chan_o, ch);
      c0 = chg_cnt;
      press(1, 0);
      chk(chan_o == (ch % 40) + 1, "R2 up step", chan_o, (ch % 40) + 1);
      chk(chg_cnt == c0 + 1, "R10 one pulse", chg_cnt, c0 + 1);
    end

    press(0, 1);
    chk(chan_o == 40, "R2 down wrap", chan_o, 40);
    press(0, 1);
    chk(chan_o == 39, "R2 down step", chan_o, 39);

    // R3: only two samples high
    up = 1'b1; cyc(2 * TICK_DIV); up = 1'b0; cyc(HOLD);
    chk(chan_o == 39, "R3 short press", chan_o, 39);

    // R9: both keys accepted on the same tick
    c0 = chg_cnt;
    press(1, 1);
    chk(chan_o == 40, "R9 up wins", chan_o, 40);
    chk(chg_cnt == c0 + 1, "R9 single pulse", chg_cnt, c0 + 1);

    // R6 / R11: emergency entry
    emg = 1'b1; cyc(1);
    chk(chg_o == 1, "R10 pulse on entry", chg_o, 1);
    chk(chan_o == 9, "R6 emergency chan", chan_o, 9);
    n = 0;
    while (!lock_o && n < 100) begin n++; cyc(1); end
    chk(n == SETTLE + 1, "R11 mask width", n, SETTLE + 1);
    lock = 1'b0; cyc(1);
    chk(lock_o == 0, "R11 follows lock low", lock_o, 0);
    lock = 1'b1; cyc(1);
    chk(lock_o == 1, "R11 follows lock high", lock_o, 1);
    press(1, 0); press(0, 1);
    chk(chan_o == 9, "R6 keys ignored", chan_o, 9);
    emg = 1'b0; cyc(2);
    chk(chan_o == 40, "R6 restore", chan_o, 40);

    // R7: hold override
    c0 = chg_cnt;
    pa = 1'b1; cyc(2);
    press(1, 0);
    emg = 1'b1; cyc(5);
    chk(chan_o == 40, "R7 emg ignored", chan_o, 40);
    emg = 1'b0; cyc(2);
    pa = 1'b0; cyc(2);
    chk(chan_o == 40, "R7 chan held", chan_o, 40);
    chk(chg_cnt == c0, "R7 no pulse", chg_cnt, c0);

    // R8: standby
    c0 = chg_cnt;
    ce = 1'b0; cyc(1);
    chk(standby_o == 1, "R8 standby flag", standby_o, 1);
    d0 = div_o;
    tx = 1'b0;
    press(1, 0);
    emg = 1'b1; cyc(5); emg = 1'b0; cyc(2);
    chk(chan_o == 40, "R8 chan frozen", chan_o, 40);
    chk(div_o == d0, "R8 div frozen", div_o, d0);
    chk(chg_cnt == c0, "R8 no pulse", chg_cnt, c0);
    ce = 1'b1; cyc(2);
    chk(standby_o == 0, "R8 resume flag", standby_o, 0);
    chk(div_o == tx_div(40) - 2139, "R5 rx after resume", div_o, tx_div(40) - 2139);
    press(1, 0);
    chk(chan_o == 1, "R2 step after resume", chan_o, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule